// File: doc/BRIEF.md
# Sector DMA Disk Read Controller

This block sits between a processor's register port and two data paths: a storage-side byte stream and a word-wide memory write port. Software programs a logical block number, a destination byte address and a positioning delay, then writes the command register last to start the read. The controller translates the block number into a surface, track and sector position using a fixed geometry. It waits the programmed number of cycles to stand in for head movement and rotation, then requests the sector from storage.

The 512 incoming bytes are packed into 32-bit words and written to consecutive word addresses starting at the destination. Every memory write waits for the memory port's ready signal. When the last word has been written, the busy flag drops and the interrupt line rises. The interrupt stays high until software clears it through the status register. A block number beyond the end of the disk is refused: the controller sets the error flag and raises the interrupt at once, and it makes no storage request and no memory write.

Top module: `sdma_read_ctrl`

## Requirements
- R1: After reset, `irq`, `disk_req`, `disk_ready` and `mem_wr_en` are low and the status register (address 4) reads 0.
- R2: The block register (address 0), destination register (address 1) and delay register (address 2) read back the last value written to them. A write to any of them while the busy flag is set is ignored.
- R3: Writing address 3 with bit 0 set while idle starts a read and sets status bit 0 (busy). The same write while busy is ignored, and no second transfer follows.
- R4: While `disk_req` is high, `disk_sector` = block mod 8, `disk_surface` = (block / 8) mod 2 and `disk_track` = block / 16 (default geometry: 8 sectors, 2 surfaces, 4 tracks, 64 blocks).
- R5: `disk_req` is high for exactly one cycle. It rises W+1 clock edges after the edge that accepts the command, where W is the delay register.
- R6: Byte k of the sector lands in bits [8*(k mod 4)+7 : 8*(k mod 4)] of word k/4. Word j is written to address destination + 4*j, and exactly 128 words are written per sector.
- R7: While `mem_wr_en` is high and `mem_wr_ready` is low, the write address and data hold steady. No byte is taken (`disk_ready` low) while a packed word waits to be written.
- R8: On the edge that completes the 128th memory write, busy clears and `irq` goes high. The status then reads 2 (interrupt pending, no error).
- R9: `irq` stays high until status bit 1 is written as 1 at address 4, and such a write clears it on the next edge.
- R10: A start command with a block number of 64 or more sets status bit 2 (error) and `irq` on the accepting edge. It leaves busy clear and produces no `disk_req` and no memory write.
- R11: A later start command with a valid block number clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0 block, 1 destination, 2 delay, 3 command, 4 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Completion or error interrupt, level |
| disk_req | output | 1 | One-cycle sector request to storage |
| disk_surface | output | 1 | Requested surface |
| disk_track | output | 2 | Requested track |
| disk_sector | output | 3 | Requested sector within the track |
| disk_byte_valid | input | 1 | Storage presents a byte |
| disk_byte | input | 8 | Sector byte from storage |
| disk_ready | output | 1 | Controller takes the byte on this edge |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Memory byte address of the word |
| mem_wr_data | output | 32 | Packed word |
| mem_wr_ready | input | 1 | Memory accepts the write on this edge |

## Verification
Every one of the 64 valid block numbers is read once, and the block numbers themselves drive a sweep of delays from 0 to 4 and four handshake patterns. The patterns are: storage and memory both always ready, storage valid on alternate cycles, memory ready one cycle in three, and a mix of irregular gaps on both sides. The always-ready pattern shows the exact request latency and the completion edge. The pattern with a slow memory is the one that exposes lost or reordered words when the packer stalls, and it also exercises address and data holding. Block-dependent byte contents separate lane placement errors from address errors. Out-of-range numbers 64 and 65535, a command issued while busy, and register writes during a transfer cover the refusal paths.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_REQ    = 2'd2,
    ST_STREAM = 2'd3
  } seq_state_e;

  localparam logic [2:0] RA_BLOCK = 3'd0;
  localparam logic [2:0] RA_DEST  = 3'd1;
  localparam logic [2:0] RA_DELAY = 3'd2;
  localparam logic [2:0] RA_CMD   = 3'd3;
  localparam logic [2:0] RA_STAT  = 3'd4;

  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_IRQ  = 1;
  localparam int unsigned STAT_ERR  = 2;
  localparam int unsigned CMD_GO    = 0;

endpackage

// File: rtl/sdma_geom.sv
module sdma_geom #(
  parameter int unsigned LBA_W  = 16,
  parameter int unsigned SPT    = 8,
  parameter int unsigned SURF   = 2,
  parameter int unsigned TRK    = 4,
  parameter int unsigned SEC_W  = 3,
  parameter int unsigned SURF_W = 1,
  parameter int unsigned TRK_W  = 2
) (
  input  logic [LBA_W-1:0]  blk,
  output logic [SEC_W-1:0]  sector,
  output logic [SURF_W-1:0] surface,
  output logic [TRK_W-1:0]  track,
  output logic              in_range
);

  localparam int unsigned CYL_BLOCKS = SPT * SURF;
  localparam int unsigned CAPACITY   = CYL_BLOCKS * TRK;

  logic [LBA_W-1:0] trk_index;

  always_comb begin
    in_range  = (32'(blk) < 32'(CAPACITY));
    trk_index = blk / LBA_W'(SPT);
    sector    = SEC_W'(blk % LBA_W'(SPT));
    surface   = SURF_W'(trk_index % LBA_W'(SURF));
    track     = TRK_W'(blk / LBA_W'(CYL_BLOCKS));
  end

endmodule

// File: rtl/sdma_packer.sv
module sdma_packer #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              clr,
  input  logic              take_en,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              byte_ready,
  input  logic              mem_ready,
  output logic              word_valid,
  output logic [DATA_W-1:0] word_data,
  output logic              word_done
);

  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [LANE_W-1:0] lane_q, lane_d;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] buf_q;
  logic [LANES-1:0]  lane_en;
  logic              accept;

  assign byte_ready = take_en & ~pend_q;
  assign accept     = byte_valid & byte_ready;
  assign word_done  = pend_q & mem_ready;
  assign word_valid = pend_q;
  assign word_data  = buf_q;

  always_comb begin
    lane_d = lane_q;
    pend_d = pend_q;
    if (clr) begin
      lane_d = '0;
      pend_d = 1'b0;
    end else begin
      if (word_done) pend_d = 1'b0;
      if (accept) begin
        if (lane_q == LAST_LANE) begin
          lane_d = '0;
          pend_d = 1'b1;
        end else begin
          lane_d = lane_q + LANE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      pend_q <= 1'b0;
    end else begin
      lane_q <= lane_d;
      pend_q <= pend_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g] = accept & (lane_q == LANE_W'(g));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        buf_q[g*8 +: 8] <= '0;
      end else if (lane_en[g]) begin
        buf_q[g*8 +: 8] <= byte_data;
      end
    end
  end

endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int unsigned WAIT_W = 8,
  parameter int unsigned WORDS  = 128,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              go,
  input  logic [WAIT_W-1:0] delay,
  input  logic [ADDR_W-1:0] dest,
  input  logic              word_done,
  output logic              disk_req,
  output logic              stream_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              done
);

  localparam int unsigned WIDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned BYTE_SH = $clog2(DATA_W / 8);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(WORDS - 1);

  seq_state_e        state_q, state_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [WIDX_W-1:0] widx_q, widx_d;

  assign disk_req  = (state_q == ST_REQ);
  assign stream_en = (state_q == ST_STREAM);
  assign wr_addr   = dest + (ADDR_W'(widx_q) << BYTE_SH);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    widx_d  = widx_q;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d = ST_WAIT;
          cnt_d   = delay;
          widx_d  = '0;
        end
      end
      ST_WAIT: begin
        if (cnt_q == '0) state_d = ST_REQ;
        else             cnt_d   = cnt_q - WAIT_W'(1);
      end
      ST_REQ: state_d = ST_STREAM;
      ST_STREAM: begin
        if (word_done) begin
          if (widx_q == LAST_WORD) begin
            state_d = ST_IDLE;
            done    = 1'b1;
          end else begin
            widx_d = widx_q + WIDX_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      widx_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      widx_q  <= widx_d;
    end
  end

endmodule

// File: rtl/sdma_read_ctrl.sv
module sdma_read_ctrl
  import sdma_pkg::*;
#(
  parameter int unsigned REG_W        = 32,
  parameter int unsigned LBA_W        = 16,
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned WAIT_W       = 8,
  parameter int unsigned SECTOR_BYTES = 512,
  parameter int unsigned SPT          = 8,
  parameter int unsigned SURF         = 2,
  parameter int unsigned TRK          = 4,
  localparam int unsigned SEC_W  = (SPT > 1) ? $clog2(SPT) : 1,
  localparam int unsigned SURF_W = (SURF > 1) ? $clog2(SURF) : 1,
  localparam int unsigned TRK_W  = (TRK > 1) ? $clog2(TRK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              disk_req,
  output logic [SURF_W-1:0] disk_surface,
  output logic [TRK_W-1:0]  disk_track,
  output logic [SEC_W-1:0]  disk_sector,
  input  logic              disk_byte_valid,
  input  logic [7:0]        disk_byte,
  output logic              disk_ready,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ready
);

  localparam int unsigned WORDS = SECTOR_BYTES / (DATA_W / 8);

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [LBA_W-1:0]  blk_q, blk_d;
  logic [ADDR_W-1:0] dest_q, dest_d;
  logic [WAIT_W-1:0] delay_q, delay_d;
  logic              busy_q, busy_d;
  logic              irq_q, irq_d;
  logic              err_q, err_d;

  logic in_range, cmd_go, start_ok, start_bad, clr_irq, done;
  logic stream_en, word_done;

  sdma_geom #(
    .LBA_W(LBA_W), .SPT(SPT), .SURF(SURF), .TRK(TRK),
    .SEC_W(SEC_W), .SURF_W(SURF_W), .TRK_W(TRK_W)
  ) u_geom (
    .blk     (blk_q),
    .sector  (disk_sector),
    .surface (disk_surface),
    .track   (disk_track),
    .in_range(in_range)
  );

  assign cmd_go    = reg_wr & (reg_addr == RA_CMD) & reg_wdata[CMD_GO] & ~busy_q;
  assign start_ok  = cmd_go & in_range;
  assign start_bad = cmd_go & ~in_range;
  assign clr_irq   = reg_wr & (reg_addr == RA_STAT) & reg_wdata[STAT_IRQ];

  always_comb begin
    blk_d   = blk_q;
    dest_d  = dest_q;
    delay_d = delay_q;
    if (reg_wr && !busy_q) begin
      if (reg_addr == RA_BLOCK) blk_d   = reg_wdata[LBA_W-1:0];
      if (reg_addr == RA_DEST)  dest_d  = reg_wdata[ADDR_W-1:0];
      if (reg_addr == RA_DELAY) delay_d = reg_wdata[WAIT_W-1:0];
    end
    busy_d = busy_q;
    if (start_ok)  busy_d = 1'b1;
    else if (done) busy_d = 1'b0;
    err_d = err_q;
    if (cmd_go) err_d = ~in_range;
    irq_d = irq_q;
    if (clr_irq) irq_d = 1'b0;
    if (done || start_bad) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q   <= '0;
      dest_q  <= '0;
      delay_q <= '0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      blk_q   <= blk_d;
      dest_q  <= dest_d;
      delay_q <= delay_d;
      busy_q  <= busy_d;
      irq_q   <= irq_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_BLOCK: reg_rdata = REG_W'(blk_q);
      RA_DEST:  reg_rdata = REG_W'(dest_q);
      RA_DELAY: reg_rdata = REG_W'(delay_q);
      RA_STAT:  reg_rdata = REG_W'({err_q, irq_q, busy_q});
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = irq_q;

  sdma_seq #(
    .WAIT_W(WAIT_W), .WORDS(WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .go       (start_ok),
    .delay    (delay_q),
    .dest     (dest_q),
    .word_done(word_done),
    .disk_req (disk_req),
    .stream_en(stream_en),
    .wr_addr  (mem_wr_addr),
    .done     (done)
  );

  sdma_packer #(
    .DATA_W(DATA_W)
  ) u_pack (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .clr       (start_ok),
    .take_en   (stream_en),
    .byte_valid(disk_byte_valid),
    .byte_data (disk_byte),
    .byte_ready(disk_ready),
    .mem_ready (mem_wr_ready),
    .word_valid(mem_wr_en),
    .word_data (mem_wr_data),
    .word_done (word_done)
  );

endmodule

// File: rtl/sdma_read_ctrl_chk.sv
module sdma_read_ctrl_chk #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              irq,
  input logic              err,
  input logic              disk_req,
  input logic              disk_ready,
  input logic              mem_wr_en,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [REG_W-1:0]  reg_wdata
);

  assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disk_req |=> !disk_req);

  assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    disk_req |-> busy);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !mem_wr_ready) |=>
      (mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_no_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !disk_ready);

  assert_done_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4 && reg_wdata[1] && !busy) |=> !irq);

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_wr_en && !disk_req && !busy));

endmodule

bind sdma_read_ctrl sdma_read_ctrl_chk #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy_q),
  .irq         (irq),
  .err         (err_q),
  .disk_req    (disk_req),
  .disk_ready  (disk_ready),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata)
);

// File: tb/test_sdma_read_ctrl.sv
module test_sdma_read_ctrl;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        disk_req;
  logic [0:0]  disk_surface;
  logic [1:0]  disk_track;
  logic [2:0]  disk_sector;
  logic        disk_byte_valid;
  logic [7:0]  disk_byte;
  logic        disk_ready;
  logic        mem_wr_en;
  logic [31:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic        mem_wr_ready;

  int total = 0;
  int bad   = 0;
  logic [31:0] img [0:127];

  sdma_read_ctrl i_sdma_read_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .disk_req(disk_req), .disk_surface(disk_surface),
    .disk_track(disk_track), .disk_sector(disk_sector),
    .disk_byte_valid(disk_byte_valid), .disk_byte(disk_byte), .disk_ready(disk_ready),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ready(mem_wr_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int blk, input int k);
    return 8'((blk * 37) + (k * 5) + ((k >> 8) * 11) + 3);
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Streams one sector and serves memory writes until irq rises.
  task automatic serve(input int blk, input logic [31:0] dest, input int mode);
    int k = 0, nw = 0, cyc = 0, last_acc = -10;
    int addr_bad = 0, hold_bad = 0, overlap = 0, data_bad = 0;
    bit prev_hold = 0;
    logic [31:0] p_addr = '0, p_data = '0, exp_w, got_w;
    bit vpat, rpat;
    while (!irq && cyc < 5000) begin
      if (prev_hold && !(mem_wr_en && mem_wr_addr == p_addr && mem_wr_data == p_data))
        hold_bad++;
      case (mode)
        0: begin vpat = 1'b1;            rpat = 1'b1; end
        1: begin vpat = cyc[0];          rpat = 1'b1; end
        2: begin vpat = 1'b1;            rpat = (cyc % 3 == 2); end
        default: begin vpat = (cyc % 5 != 1); rpat = cyc[1]; end
      endcase
      mem_wr_ready = rpat;
      if (mem_wr_en && mem_wr_ready) begin
        if (mem_wr_addr[1:0] != 2'b00 || mem_wr_addr < dest || (mem_wr_addr - dest) >= 32'd512)
          addr_bad++;
        else
          img[(mem_wr_addr - dest) >> 2] = mem_wr_data;
        nw++;
        last_acc = cyc;
      end
      prev_hold = mem_wr_en && !mem_wr_ready;
      p_addr = mem_wr_addr; p_data = mem_wr_data;
      if (disk_ready && mem_wr_en) overlap++;
      if (k < 512 && vpat) begin
        disk_byte_valid = 1'b1;
        disk_byte = pat(blk, k);
        if (disk_ready) k++;
      end else begin
        disk_byte_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    disk_byte_valid = 1'b0;
    mem_wr_ready = 1'b0;
    check(nw == 128, "R6", "word write count", nw, 128);
    check(addr_bad == 0, "R6", "write addresses outside sector window", addr_bad, 0);
    for (int j = 0; j < 128; j++) begin
      exp_w = {pat(blk, 4*j+3), pat(blk, 4*j+2), pat(blk, 4*j+1), pat(blk, 4*j)};
      got_w = img[j];
      if (got_w !== exp_w) begin
        if (data_bad == 0) check(1'b0, "R6", $sformatf("word %0d blk %0d", j, blk), got_w, exp_w);
        data_bad++;
      end
    end
    if (data_bad == 0) check(1'b1, "R6", "sector contents", 0, 0);
    check(hold_bad == 0, "R7", "write held while not ready", hold_bad, 0);
    check(overlap == 0, "R7", "byte taken while word pending", overlap, 0);
    check(irq && cyc == last_acc + 1, "R8", "irq edge after last write", cyc - last_acc, 1);
  endtask

  task automatic transfer(input int blk, input logic [31:0] dest, input int w,
                          input int mode, input bit timed);
    int n;
    logic [31:0] st;
    reg_write(3'd4, 32'h2);
    reg_write(3'd0, 32'(blk));
    reg_write(3'd1, dest);
    reg_write(3'd2, 32'(w));
    reg_write(3'd3, 32'h1);
    n = 1;
    while (!disk_req && n < 1000) begin @(negedge clk); n++; end
    if (timed) check(n == w + 2, "R5", "request latency in negedges", n, w + 2);
    check({disk_track, disk_surface, disk_sector} == 6'(blk), "R4",
          $sformatf("position of blk %0d", blk),
          {disk_track, disk_surface, disk_sector}, 6'(blk));
    @(negedge clk);
    check(!disk_req, "R5", "request lasts one cycle", disk_req, 0);
    for (int j = 0; j < 128; j++) img[j] = 32'hDEAD_BEEF;
    serve(blk, dest, mode);
    reg_read(3'd4, st);
    check(st == 32'h2, "R8", "status after completion", st, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int reqs, wrs;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    disk_byte_valid = 1'b0; disk_byte = '0; mem_wr_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check(!irq && !disk_req && !disk_ready && !mem_wr_en, "R1", "outputs after reset",
          {irq, disk_req, disk_ready, mem_wr_en}, 0);
    reg_read(3'd4, d);
    check(d == 0, "R1", "status after reset", d, 0);

    reg_write(3'd0, 32'h1234);
    reg_write(3'd1, 32'hCAFE_0000);
    reg_write(3'd2, 32'h5A);
    reg_read(3'd0, d); check(d == 32'h1234, "R2", "block readback", d, 32'h1234);
    reg_read(3'd1, d); check(d == 32'hCAFE_0000, "R2", "destination readback", d, 32'hCAFE_0000);
    reg_read(3'd2, d); check(d == 32'h5A, "R2", "delay readback", d, 32'h5A);

    for (int b = 0; b < 64; b++)
      transfer(b, 32'h1000_0000 + 32'(b) * 32'h400, b % 5, b % 4, 1'b1);

    // R9: irq holds without a clear
    repeat (10) @(negedge clk);
    check(irq, "R9", "irq holds until cleared", irq, 1);
    reg_write(3'd4, 32'h2);
    check(!irq, "R9", "irq cleared by status write", irq, 0);

    // R2/R3: writes while busy are ignored
    reg_write(3'd0, 32'd3);
    reg_write(3'd1, 32'h2000_0000);
    reg_write(3'd2, 32'd40);
    reg_write(3'd3, 32'h1);
    reg_write(3'd0, 32'd9);
    reg_write(3'd1, 32'h0);
    reg_write(3'd3, 32'h1);
    reg_read(3'd4, d); check(d == 32'h1, "R3", "busy set while transfer runs", d, 1);
    reg_read(3'd0, d); check(d == 32'd3, "R2", "block write ignored while busy", d, 3);
    reg_read(3'd1, d); check(d == 32'h2000_0000, "R2", "destination write ignored while busy", d, 32'h2000_0000);
    while (!disk_req) @(negedge clk);
    check({disk_track, disk_surface, disk_sector} == 6'd3, "R4", "position for busy test",
          {disk_track, disk_surface, disk_sector}, 3);
    @(negedge clk);
    for (int j = 0; j < 128; j++) img[j] = 32'hDEAD_BEEF;
    serve(3, 32'h2000_0000, 0);
    reqs = 0;
    for (int c = 0; c < 60; c++) begin @(negedge clk); if (disk_req) reqs++; end
    check(reqs == 0, "R3", "no second transfer after ignored command", reqs, 0);

    // R10: out of range blocks
    foreach (d[i]) ;
    for (int t = 0; t < 2; t++) begin
      reg_write(3'd4, 32'h2);
      reg_write(3'd0, (t == 0) ? 32'd64 : 32'd65535);
      reg_write(3'd3, 32'h1);
      check(irq, "R10", "irq on refused block", irq, 1);
      reg_read(3'd4, d); check(d == 32'h6, "R10", "status on refused block", d, 6);
      reqs = 0; wrs = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (disk_req) reqs++;
        if (mem_wr_en) wrs++;
      end
      check(reqs == 0 && wrs == 0, "R10", "no activity on refused block", reqs + wrs, 0);
      reg_write(3'd4, 32'h2);
      reg_read(3'd4, d); check(d == 32'h4, "R9", "clear leaves error bit", d, 4);
    end

    // R11: next valid command clears error
    transfer(63, 32'h3000_0100, 2, 2, 1'b1);
    reg_read(3'd4, d); check(d[2] == 1'b0, "R11", "error cleared by valid command", d, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule